// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames on a single line and places the data bytes into a small receive queue. A pulse from an external 16x oversampling tick paces the receiver, and the line is sampled in the middle of each bit. Each frame has one start bit, eight data bits sent least significant bit first, one extra bit that tags the frame as an address or as data, and one stop bit.

On a shared bus, several stations listen to the same line. A station can arm a hardware filter so that it ignores all traffic until an address-tagged frame arrives. While the filter is armed, untagged frames leave no trace: nothing is queued, nothing is checked and no flag or request moves. When a tagged frame arrives, the filter disarms itself, records the tag and handles that frame normally. Software then reads the address byte and decides whether to keep listening or to re-arm the filter.

Error flags are sticky. They are cleared only by their own clear strobes, and turning the receiver off leaves them unchanged.

Top module: `mpu_wake_rx`

## Requirements
- R1: While `rx_en` is 0, no frame is started. A frame sent on the line leaves `dr` at 0, and a frame that is in progress is abandoned when `rx_en` falls.
- R2: A frame is a 0 start bit, 8 data bits sent least significant bit first, a tag bit and a stop bit, each 16 ticks long. The received byte appears on `rd_data` in order of arrival.
- R3: Dropping `rx_en` to 0 leaves `fer`, `ovr`, `dr` and the queued bytes unchanged.
- R4: When `mp_fmt` is 0, the value of `mpie` has no effect. Untagged frames are queued and `mpie` keeps its value.
- R5: While `mp_fmt` and `mpie` are both 1, a frame with tag 0 is not queued. It does not set `fer` or `ovr`, even when its stop bit is 0, and it does not change `mpb`, `rxi` or `eri`.
- R6: A frame with tag 1 that arrives while the filter is armed clears `mpie` to 0, sets `mpb` to 1 and is itself queued.
- R7: When the filter is not armed, every accepted frame copies its tag bit into `mpb`.
- R8: A pulse on `mpie_wr` loads `mpie_wdata` into `mpie`. Writing 0 disarms the filter, so that the next untagged frame is queued.
- R9: The queue holds 16 bytes. `dr` is 1 exactly when at least one byte is queued, and `rd_en` pops the byte shown on `rd_data`.
- R10: A frame that completes while the queue is full sets `ovr` and is dropped. The 16 queued bytes are kept.
- R11: A stop bit that samples as 0 sets `fer`. The byte of that frame is still queued.
- R12: `rxi` equals `rie` AND `dr`. `eri` equals `rie` AND (`fer` OR `ovr`).
- R13: A pulse on `fer_clr` clears `fer`, and a pulse on `ovr_clr` clears `ovr`.
- R14: A low level on the line that is no longer low half a bit later is treated as noise, and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| mp_fmt | input | 1 | Frames carry a tag bit, filter usable |
| rie | input | 1 | Receive and error request enable |
| mpie_wr | input | 1 | Write strobe for the filter enable |
| mpie_wdata | input | 1 | Value written to the filter enable |
| fer_clr | input | 1 | Clear strobe for the framing error flag |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| rd_en | input | 1 | Pop the head of the receive queue |
| rd_data | output | 8 | Head of the receive queue |
| dr | output | 1 | Receive queue not empty |
| fer | output | 1 | Framing error flag |
| ovr | output | 1 | Overrun flag |
| mpb | output | 1 | Tag bit of the last accepted frame |
| mpie | output | 1 | Filter armed |
| rxi | output | 1 | Receive request |
| eri | output | 1 | Error request |

## Verification
The bench builds the block with its default parameters: 8 data bits, 16 ticks per bit and a 16-entry queue. It drives the tick on every second clock, so one bit lasts 32 clocks. With these values the bench can fill the queue and trigger an overrun using 17 frames, and it can place a false start shorter than half a bit. The filter tests send untagged frames with a bad stop bit while the filter is armed, which shows that error checking is really suppressed. They also check that the releasing frame is queued.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

  typedef enum logic [2:0] {
    RS_IDLE  = 3'd0,
    RS_START = 3'd1,
    RS_BITS  = 3'd2,
    RS_STOP  = 3'd3,
    RS_WAIT  = 3'd4
  } rx_state_e;

endpackage

// File: rtl/mpw_rx_frame.sv
module mpw_rx_frame
  import mpw_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              tick,
  input  logic              enable,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              tag,
  output logic              stop_bit,
  output logic              idle
);

  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int BW   = $clog2(DATA_W + 1);
  localparam int SW   = DATA_W + 1;
  localparam logic [CW-1:0] HALF = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] NBIT = BW'(DATA_W);

  logic [1:0]    sync_q;
  logic          line;
  rx_state_e     st_q, st_n;
  logic [CW-1:0] tc_q, tc_n;
  logic [BW-1:0] bc_q, bc_n;
  logic [SW-1:0] sh_q, sh_n;
  logic          done_q, done_n;
  logic          stop_q, stop_n;

  assign line = sync_q[1];

  always_comb begin
    st_n   = st_q;
    tc_n   = tc_q;
    bc_n   = bc_q;
    sh_n   = sh_q;
    done_n = 1'b0;
    stop_n = stop_q;
    if (!enable) begin
      st_n = RS_IDLE;
      tc_n = '0;
    end else begin
      unique case (st_q)
        RS_IDLE: begin
          if (tick && !line) begin
            st_n = RS_START;
            tc_n = '0;
          end
        end
        RS_START: begin
          if (tick) begin
            if (tc_q == HALF) begin
              tc_n = '0;
              bc_n = '0;
              st_n = line ? RS_IDLE : RS_BITS;
            end else begin
              tc_n = tc_q + 1'b1;
            end
          end
        end
        RS_BITS: begin
          if (tick) begin
            if (tc_q == LAST) begin
              tc_n = '0;
              sh_n = {line, sh_q[SW-1:1]};
              if (bc_q == NBIT) st_n = RS_STOP;
              else              bc_n = bc_q + 1'b1;
            end else begin
              tc_n = tc_q + 1'b1;
            end
          end
        end
        RS_STOP: begin
          if (tick) begin
            if (tc_q == LAST) begin
              tc_n   = '0;
              done_n = 1'b1;
              stop_n = line;
              st_n   = RS_WAIT;
            end else begin
              tc_n = tc_q + 1'b1;
            end
          end
        end
        RS_WAIT: begin
          if (line) st_n = RS_IDLE;
        end
        default: st_n = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RS_IDLE;
      tc_q   <= '0;
      bc_q   <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rxd};
      st_q   <= st_n;
      tc_q   <= tc_n;
      bc_q   <= bc_n;
      sh_q   <= sh_n;
      done_q <= done_n;
      stop_q <= stop_n;
    end
  end

  assign done     = done_q;
  assign data     = sh_q[DATA_W-1:0];
  assign tag      = sh_q[SW-1];
  assign stop_bit = stop_q;
  assign idle     = (st_q == RS_IDLE);

endmodule

// File: rtl/mpw_rx_fifo.sv
module mpw_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [$clog2(DEPTH):0] count
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp_q, wp_n, rp_q, rp_n;
  logic             do_wr, do_rd;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign count = wp_q - rp_q;
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_n = do_wr ? wp_q + 1'b1 : wp_q;
    rp_n = do_rd ? rp_q + 1'b1 : rp_q;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
    end
  end

endmodule

// File: rtl/mpw_rx_ctl.sv
module mpw_rx_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic tag,
  input  logic stop_bit,
  input  logic mp_fmt,
  input  logic mpie_wr,
  input  logic mpie_wdata,
  input  logic fer_clr,
  input  logic ovr_clr,
  input  logic fifo_full,
  output logic fifo_wr,
  output logic fer,
  output logic ovr,
  output logic mpb,
  output logic mpie
);

  logic armed, release_f, accept;
  logic mpie_q, mpie_n, fer_q, fer_n, ovr_q, ovr_n, mpb_q, mpb_n;

  always_comb begin
    armed     = mp_fmt && mpie_q;
    release_f = done && armed && tag;
    accept    = done && (!armed || tag);
    fifo_wr   = accept && !fifo_full;

    if (release_f)    mpie_n = 1'b0;
    else if (mpie_wr) mpie_n = mpie_wdata;
    else              mpie_n = mpie_q;

    if (accept && !stop_bit) fer_n = 1'b1;
    else if (fer_clr)        fer_n = 1'b0;
    else                     fer_n = fer_q;

    if (accept && fifo_full) ovr_n = 1'b1;
    else if (ovr_clr)        ovr_n = 1'b0;
    else                     ovr_n = ovr_q;

    mpb_n = accept ? tag : mpb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpie_q <= 1'b0;
      fer_q  <= 1'b0;
      ovr_q  <= 1'b0;
      mpb_q  <= 1'b0;
    end else begin
      mpie_q <= mpie_n;
      fer_q  <= fer_n;
      ovr_q  <= ovr_n;
      mpb_q  <= mpb_n;
    end
  end

  assign fer  = fer_q;
  assign ovr  = ovr_q;
  assign mpb  = mpb_q;
  assign mpie = mpie_q;

endmodule

// File: rtl/mpu_wake_rx.sv
module mpu_wake_rx #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              mp_fmt,
  input  logic              rie,
  input  logic              mpie_wr,
  input  logic              mpie_wdata,
  input  logic              fer_clr,
  input  logic              ovr_clr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              dr,
  output logic              fer,
  output logic              ovr,
  output logic              mpb,
  output logic              mpie,
  output logic              rxi,
  output logic              eri
);

  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              fr_done, fr_tag, fr_stop, fr_idle;
  logic [DATA_W-1:0] fr_data;
  logic              fifo_wr, fifo_full, fifo_empty;
  logic [CNT_W-1:0]  fifo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mpw_rx_frame #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) i_frame (
    .clk(clk), .rst_n(rst_int_n), .rxd(rxd), .tick(tick16), .enable(rx_en),
    .done(fr_done), .data(fr_data), .tag(fr_tag), .stop_bit(fr_stop), .idle(fr_idle)
  );

  mpw_rx_ctl i_ctl (
    .clk(clk), .rst_n(rst_int_n), .done(fr_done), .tag(fr_tag), .stop_bit(fr_stop),
    .mp_fmt(mp_fmt), .mpie_wr(mpie_wr), .mpie_wdata(mpie_wdata),
    .fer_clr(fer_clr), .ovr_clr(ovr_clr), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fer(fer), .ovr(ovr), .mpb(mpb), .mpie(mpie)
  );

  mpw_rx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_int_n), .wr(fifo_wr), .wdata(fr_data), .rd(rd_en),
    .rdata(rd_data), .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
  );

  assign dr  = !fifo_empty;
  assign rxi = rie && dr;
  assign eri = rie && (fer || ovr);

endmodule

// File: rtl/mpw_rx_chk.sv
module mpw_rx_chk #(
  parameter int FIFO_DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic mp_fmt,
  input logic fer_clr,
  input logic ovr_clr,
  input logic fer,
  input logic ovr,
  input logic mpb,
  input logic mpie,
  input logic fr_done,
  input logic fr_tag,
  input logic fr_idle,
  input logic fifo_wr,
  input logic fifo_full,
  input logic [$clog2(FIFO_DEPTH):0] fifo_cnt
);

  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> fr_idle);

  p_fer_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fer && !fer_clr) |=> fer);

  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

  p_filter_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && mp_fmt && mpie && !fr_tag) |-> !fifo_wr);

  p_filter_no_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && mp_fmt && mpie && !fr_tag) |=> (!$rose(fer) && !$rose(ovr)));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && mp_fmt && mpie && fr_tag) |=> (!mpie && mpb));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  p_ovr_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(fifo_full));

endmodule

bind mpu_wake_rx mpw_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mp_fmt(mp_fmt),
  .fer_clr(fer_clr), .ovr_clr(ovr_clr), .fer(fer), .ovr(ovr), .mpb(mpb),
  .mpie(mpie), .fr_done(fr_done), .fr_tag(fr_tag), .fr_idle(fr_idle),
  .fifo_wr(fifo_wr), .fifo_full(fifo_full), .fifo_cnt(fifo_cnt)
);

// File: tb/test_mpu_wake_rx.sv
`timescale 1ns/1ps
module test_mpu_wake_rx;

  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rst_n, rxd, tick16, rx_en, mp_fmt, rie;
  logic       mpie_wr, mpie_wdata, fer_clr, ovr_clr, rd_en;
  logic [7:0] rd_data;
  logic       dr, fer, ovr, mpb, mpie, rxi, eri;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  mpu_wake_rx i_mpu_wake_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .rx_en(rx_en),
    .mp_fmt(mp_fmt), .rie(rie), .mpie_wr(mpie_wr), .mpie_wdata(mpie_wdata),
    .fer_clr(fer_clr), .ovr_clr(ovr_clr), .rd_en(rd_en), .rd_data(rd_data),
    .dr(dr), .fer(fer), .ovr(ovr), .mpb(mpb), .mpie(mpie), .rxi(rxi), .eri(eri)
  );

  initial begin
    tick16 = 1'b0;
    forever begin
      @(negedge clk); tick16 = 1'b1;
      @(negedge clk); tick16 = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int bits);
    rxd = 1'b1;
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic tag, input logic stop);
    logic [10:0] fr;
    fr = {stop, tag, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = fr[i];
      repeat (BITCLK) @(negedge clk);
    end
    idle(2);
  endtask

  task automatic pulse_mpie(input logic v);
    mpie_wdata = v; mpie_wr = 1'b1;
    @(negedge clk); mpie_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop(input string req, input logic [7:0] exp);
    check(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R9 reset dr", dr, 0);
    check("R13 reset fer", fer, 0);
    check("R10 reset ovr", ovr, 0);
    check("R6 reset mpb", mpb, 0);
    check("R8 reset mpie", mpie, 0);
    check("R12 reset rxi", rxi, 0);
    check("R12 reset eri", eri, 0);
  endtask

  task automatic t_disabled;
    rx_en = 1'b0;
    send(8'hA5, 1'b0, 1'b1);
    check("R1 frame while disabled", dr, 0);
    rx_en = 1'b1;
    idle(1);
  endtask

  task automatic t_basic;
    send(8'h3C, 1'b0, 1'b1);
    check("R9 dr after frame", dr, 1);
    check("R12 rxi with rie", rxi, 1);
    pop("R2 first byte", 8'h3C);
    check("R9 dr after pop", dr, 0);
    send(8'h81, 1'b0, 1'b1);
    send(8'h5A, 1'b0, 1'b1);
    pop("R2 order a", 8'h81);
    pop("R2 order b", 8'h5A);
    check("R12 rxi empty", rxi, 0);
  endtask

  task automatic t_false_start;
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    idle(3);
    check("R14 glitch ignored", dr, 0);
  endtask

  task automatic t_fmt_off;
    mp_fmt = 1'b0;
    pulse_mpie(1'b1);
    send(8'h11, 1'b0, 1'b1);
    check("R4 queued with fmt off", dr, 1);
    check("R4 mpie kept", mpie, 1);
    pop("R4 byte", 8'h11);
    pulse_mpie(1'b0);
  endtask

  task automatic t_filter;
    mp_fmt = 1'b1;
    pulse_mpie(1'b1);
    send(8'h22, 1'b0, 1'b0);
    check("R5 not queued", dr, 0);
    check("R5 no fer", fer, 0);
    check("R5 no eri", eri, 0);
    check("R5 mpb unchanged", mpb, 0);
    check("R5 still armed", mpie, 1);
    send(8'h33, 1'b1, 1'b1);
    check("R6 mpie cleared", mpie, 0);
    check("R6 mpb set", mpb, 1);
    check("R6 release frame queued", dr, 1);
    pop("R6 address byte", 8'h33);
    send(8'h44, 1'b0, 1'b1);
    check("R7 mpb follows tag", mpb, 0);
    pop("R7 data byte", 8'h44);
    send(8'h45, 1'b1, 1'b1);
    check("R7 mpb tag one", mpb, 1);
    pop("R7 tagged byte", 8'h45);
  endtask

  task automatic t_sw_clear;
    pulse_mpie(1'b1);
    check("R8 write one", mpie, 1);
    pulse_mpie(1'b0);
    check("R8 write zero", mpie, 0);
    send(8'h55, 1'b0, 1'b1);
    pop("R8 queued after disarm", 8'h55);
  endtask

  task automatic t_framing;
    send(8'h66, 1'b0, 1'b0);
    check("R11 fer set", fer, 1);
    check("R12 eri on fer", eri, 1);
    rie = 1'b0;
    @(negedge clk);
    check("R12 eri masked", eri, 0);
    rie = 1'b1;
    pop("R11 byte kept", 8'h66);
  endtask

  task automatic t_hold;
    send(8'h77, 1'b0, 1'b1);
    rx_en = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 fer held", fer, 1);
    check("R3 dr held", dr, 1);
    rx_en = 1'b1;
    fer_clr = 1'b1; @(negedge clk); fer_clr = 1'b0; @(negedge clk);
    check("R13 fer cleared", fer, 0);
    pop("R3 byte held", 8'h77);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 16; i++) send(8'(8'h90 + i), 1'b0, 1'b1);
    check("R10 no ovr at full", ovr, 0);
    send(8'hEE, 1'b0, 1'b1);
    check("R10 ovr set", ovr, 1);
    check("R12 eri on ovr", eri, 1);
    for (int i = 0; i < 16; i++) pop("R9 depth data", 8'(8'h90 + i));
    check("R10 extra frame dropped", dr, 0);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    check("R13 ovr cleared", ovr, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b1; mp_fmt = 1'b0; rie = 1'b1;
    mpie_wr = 1'b0; mpie_wdata = 1'b0; fer_clr = 1'b0; ovr_clr = 1'b0; rd_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_false_start();
    t_fmt_off();
    t_filter();
    t_sw_clear();
    t_framing();
    t_hold();
    t_overrun();
    finish_run();
  end

endmodule